// File: doc/BRIEF.md
# CEC Signal-Free-Time Start Controller

This block decides when the signal-free-time counter of a CEC bus interface starts or restarts, and it runs that counter. A message can end in several ways: a normal end of transmission or reception, a transmit error, a missing acknowledge, a transmit underrun, a receive abort, a receive abort followed by a driven error bit, or a bad start bit. The framing logic reports each of these as a single-cycle event. A flagged event places the counter's zero point at the moment that the event itself marks. The only exceptions are the error-bit case and the bad-start case. In those two cases the counter is held at zero until the error bit ends or until the line is released to idle.

Time comes from an external fixed tick. A programmable number of ticks makes up one nominal data-bit period, and the counter counts whole bit periods. It saturates at its maximum value. A second output is high when the count has reached a threshold set by the caller and the line is idle high. Any low level seen on the line clears the count. The arbitration logic uses the elapsed output to decide when it may take the bus.

Top module: `cec_sft_start_ctrl`

## Requirements
- R1: After reset, `sft_count` is 0, `sft_elapsed` is 0 and the controller is in the running state.
- R2: While running with `bus_high`=1 and no event, `sft_count` goes up by one on every TICKS_PER_BIT-th `tick` pulse. It saturates at 2**CNT_W-1, which is 15 by default.
- R3: A pulse on `ev_tx_done`, `ev_rx_done`, `ev_tx_err`, `ev_tx_noack` or `ev_tx_underrun`, or on `ev_rx_abort` with `rx_abort_errbit`=0, sets the count and the sub-bit tick phase to 0 at the next edge. Counting then restarts from that point.
- R4: `ev_rx_abort` together with `rx_abort_errbit`=1 holds the count at 0, whatever the ticks and the bus level. The hold lasts until an `errbit_end` pulse, and counting restarts from zero after that pulse.
- R5: `ev_bad_start` holds the count at 0 until a cycle in which `bus_high`=1. Counting restarts from zero in that cycle.
- R6: While running, any cycle with `bus_high`=0 clears the count and the sub-bit tick phase at the next edge. Ticks seen while the bus is low have no effect.
- R7: `sft_elapsed` is registered. After each edge it is 1 exactly when the controller is running, `bus_high` was 1 and the new count is at least `sft_thresh`. This includes the case of threshold 0.
- R8: When events arrive in the same cycle, the later start point wins. A receive abort with an error bit beats a bad start, and a bad start beats any of the immediate events of R3.
- R9: While the controller is holding after a bad start, an `errbit_end` pulse has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Fixed time-base pulse |
| bus_high | input | 1 | Sampled line level, 1 = released/idle |
| ev_tx_done | input | 1 | Transmit end-of-message flag raised |
| ev_rx_done | input | 1 | Receive end-of-message flag raised |
| ev_tx_err | input | 1 | Transmit error detected |
| ev_tx_noack | input | 1 | Missing acknowledge flag raised |
| ev_tx_underrun | input | 1 | Transmit underrun flag raised |
| ev_rx_abort | input | 1 | Receive error aborting reception |
| rx_abort_errbit | input | 1 | Qualifies ev_rx_abort: an error bit will be driven |
| errbit_end | input | 1 | Driven error bit has finished |
| ev_bad_start | input | 1 | Wrong start bit or unexpected low from idle |
| sft_thresh | input | CNT_W | Requested signal-free length in bit periods |
| sft_count | output | CNT_W | Elapsed signal-free time in bit periods |
| sft_elapsed | output | 1 | Requested signal-free time has elapsed |

## Verification
The bench builds the block with TICKS_PER_BIT=3 and the default CNT_W=4. At this size a full climb to the saturation value of 15 takes only about 45 cycles, so saturation, threshold crossings and restarts in the middle of a bit period can all be reached in a short run. The tick is sometimes pulsed on every cycle and sometimes on every second or third cycle. This shows that the sub-bit phase is cleared together with the count and that it counts only real ticks.

// File: rtl/cec_sft_pkg.sv
package cec_sft_pkg;
  typedef enum logic [1:0] {
    ST_RUN         = 2'd0,
    ST_HOLD_ERRBIT = 2'd1,
    ST_HOLD_IDLE   = 2'd2
  } sft_state_t;

  typedef enum logic [1:0] {
    ACT_NONE        = 2'd0,
    ACT_START       = 2'd1,
    ACT_WAIT_ERRBIT = 2'd2,
    ACT_WAIT_IDLE   = 2'd3
  } sft_act_t;
endpackage

// File: rtl/cec_sft_arbiter.sv
module cec_sft_arbiter
  import cec_sft_pkg::*;
(
  input  sft_state_t state,
  input  logic       bus_high,
  input  logic       ev_tx_done,
  input  logic       ev_rx_done,
  input  logic       ev_tx_err,
  input  logic       ev_tx_noack,
  input  logic       ev_tx_underrun,
  input  logic       ev_rx_abort,
  input  logic       rx_abort_errbit,
  input  logic       errbit_end,
  input  logic       ev_bad_start,
  output sft_act_t   act,
  output sft_state_t state_nxt
);
  logic immediate;

  assign immediate = ev_tx_done | ev_rx_done | ev_tx_err | ev_tx_noack |
                     ev_tx_underrun | (ev_rx_abort & ~rx_abort_errbit);

  // Later start point wins: error-bit end > line release > immediate flag
  always_comb begin
    act = ACT_NONE;
    if (ev_rx_abort && rx_abort_errbit)        act = ACT_WAIT_ERRBIT;
    else if (ev_bad_start)                     act = ACT_WAIT_IDLE;
    else if (immediate)                        act = ACT_START;
    else if (state == ST_HOLD_ERRBIT && errbit_end) act = ACT_START;
    else if (state == ST_HOLD_IDLE && bus_high)     act = ACT_START;
  end

  always_comb begin
    unique case (act)
      ACT_WAIT_ERRBIT: state_nxt = ST_HOLD_ERRBIT;
      ACT_WAIT_IDLE:   state_nxt = ST_HOLD_IDLE;
      ACT_START:       state_nxt = ST_RUN;
      default:         state_nxt = state;
    endcase
  end
endmodule

// File: rtl/cec_sft_bitclk.sv
module cec_sft_bitclk #(
  parameter int TICKS_PER_BIT = 24
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic tick,
  output logic bit_done
);
  localparam int SUB_W = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(TICKS_PER_BIT - 1);

  logic [SUB_W-1:0] sub_q;

  assign bit_done = ~clr & tick & (sub_q == SUB_LAST);

  always_ff @(posedge clk) begin
    if (rst || clr)     sub_q <= '0;
    else if (bit_done)  sub_q <= '0;
    else if (tick)      sub_q <= sub_q + 1'b1;
  end
endmodule

// File: rtl/cec_sft_counter.sv
module cec_sft_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_nxt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_comb begin
    cnt_nxt = cnt_q;
    if (clr)                         cnt_nxt = '0;
    else if (inc && cnt_q != CNT_MAX) cnt_nxt = cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/cec_sft_start_ctrl.sv
module cec_sft_start_ctrl
  import cec_sft_pkg::*;
#(
  parameter int TICKS_PER_BIT = 24,
  parameter int CNT_W         = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             bus_high,
  input  logic             ev_tx_done,
  input  logic             ev_rx_done,
  input  logic             ev_tx_err,
  input  logic             ev_tx_noack,
  input  logic             ev_tx_underrun,
  input  logic             ev_rx_abort,
  input  logic             rx_abort_errbit,
  input  logic             errbit_end,
  input  logic             ev_bad_start,
  input  logic [CNT_W-1:0] sft_thresh,
  output logic [CNT_W-1:0] sft_count,
  output logic             sft_elapsed
);
  sft_state_t       state_q, state_nxt;
  sft_act_t         act;
  logic             clr, bit_done;
  logic [CNT_W-1:0] cnt_nxt;

  cec_sft_arbiter u_arb (
    .state          (state_q),
    .bus_high       (bus_high),
    .ev_tx_done     (ev_tx_done),
    .ev_rx_done     (ev_rx_done),
    .ev_tx_err      (ev_tx_err),
    .ev_tx_noack    (ev_tx_noack),
    .ev_tx_underrun (ev_tx_underrun),
    .ev_rx_abort    (ev_rx_abort),
    .rx_abort_errbit(rx_abort_errbit),
    .errbit_end     (errbit_end),
    .ev_bad_start   (ev_bad_start),
    .act            (act),
    .state_nxt      (state_nxt)
  );

  // Count only while running undisturbed on an idle line
  assign clr = (act != ACT_NONE) || (state_q != ST_RUN) || !bus_high;

  cec_sft_bitclk #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_bitclk (
    .clk     (clk),
    .rst     (rst),
    .clr     (clr),
    .tick    (tick),
    .bit_done(bit_done)
  );

  cec_sft_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .clr    (clr),
    .inc    (bit_done),
    .cnt_q  (sft_count),
    .cnt_nxt(cnt_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_RUN;
      sft_elapsed <= 1'b0;
    end else begin
      state_q     <= state_nxt;
      sft_elapsed <= (state_nxt == ST_RUN) && bus_high && (cnt_nxt >= sft_thresh);
    end
  end
endmodule

// File: rtl/cec_sft_checker.sv
module cec_sft_checker
  import cec_sft_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_high,
  input logic             ev_tx_done,
  input logic             ev_rx_done,
  input logic             ev_tx_err,
  input logic             ev_tx_noack,
  input logic             ev_tx_underrun,
  input logic             ev_rx_abort,
  input logic             rx_abort_errbit,
  input logic             ev_bad_start,
  input logic [CNT_W-1:0] sft_thresh,
  input logic [CNT_W-1:0] sft_count,
  input logic             sft_elapsed,
  input sft_state_t       state_q
);
  assert_step_R2: assert property (@(posedge clk) disable iff (rst)
    (sft_count != $past(sft_count)) |->
      (sft_count == $past(sft_count) + 1'b1 || sft_count == '0));

  assert_restart_R3: assert property (@(posedge clk) disable iff (rst)
    ((ev_tx_done | ev_rx_done | ev_tx_err | ev_tx_noack | ev_tx_underrun | ev_rx_abort)
      && !ev_bad_start && !rx_abort_errbit) |=> (sft_count == '0));

  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_HOLD_ERRBIT) |-> (sft_count == '0 && !sft_elapsed));

  assert_low_clears_R6: assert property (@(posedge clk) disable iff (rst)
    !bus_high |=> (sft_count == '0 && !sft_elapsed));

  assert_elapsed_R7: assert property (@(posedge clk) disable iff (rst)
    sft_elapsed |-> (sft_count >= $past(sft_thresh)));

  assert_priority_R8: assert property (@(posedge clk) disable iff (rst)
    (ev_rx_abort && rx_abort_errbit) |=> (state_q == ST_HOLD_ERRBIT));
endmodule

bind cec_sft_start_ctrl cec_sft_checker #(.CNT_W(CNT_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .bus_high       (bus_high),
  .ev_tx_done     (ev_tx_done),
  .ev_rx_done     (ev_rx_done),
  .ev_tx_err      (ev_tx_err),
  .ev_tx_noack    (ev_tx_noack),
  .ev_tx_underrun (ev_tx_underrun),
  .ev_rx_abort    (ev_rx_abort),
  .rx_abort_errbit(rx_abort_errbit),
  .ev_bad_start   (ev_bad_start),
  .sft_thresh     (sft_thresh),
  .sft_count      (sft_count),
  .sft_elapsed    (sft_elapsed),
  .state_q        (state_q)
);

// File: tb/sim_cec_sft_start_ctrl.sv
module sim_cec_sft_start_ctrl;
  localparam int TPB   = 3;
  localparam int CNT_W = 4;
  localparam int CMAX  = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0, bus_high = 1'b1;
  logic ev_tx_done = 0, ev_rx_done = 0, ev_tx_err = 0, ev_tx_noack = 0;
  logic ev_tx_underrun = 0, ev_rx_abort = 0, rx_abort_errbit = 0;
  logic errbit_end = 0, ev_bad_start = 0;
  logic [CNT_W-1:0] sft_thresh = 4'd5;
  logic [CNT_W-1:0] sft_count;
  logic sft_elapsed;

  always #10 clk = ~clk;

  cec_sft_start_ctrl #(.TICKS_PER_BIT(TPB), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst(rst), .tick(tick), .bus_high(bus_high),
    .ev_tx_done(ev_tx_done), .ev_rx_done(ev_rx_done), .ev_tx_err(ev_tx_err),
    .ev_tx_noack(ev_tx_noack), .ev_tx_underrun(ev_tx_underrun),
    .ev_rx_abort(ev_rx_abort), .rx_abort_errbit(rx_abort_errbit),
    .errbit_end(errbit_end), .ev_bad_start(ev_bad_start),
    .sft_thresh(sft_thresh), .sft_count(sft_count), .sft_elapsed(sft_elapsed)
  );

  int checks = 0, errors = 0;
  string req = "R1";
  int tick_div = 1, tick_ctr = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: mode 0 running, 1 waiting error bit, 2 waiting idle
  int m_mode = 0, m_sub = 0, m_cnt = 0;
  bit m_el = 0;
  always @(posedge clk) begin
    if (rst) begin
      m_mode = 0; m_sub = 0; m_cnt = 0; m_el = 0;
    end else begin
      int nm; bit zero;
      nm = m_mode; zero = 1'b0;
      if (ev_rx_abort && rx_abort_errbit) begin nm = 1; zero = 1; end
      else if (ev_bad_start) begin nm = 2; zero = 1; end
      else if (ev_tx_done || ev_rx_done || ev_tx_err || ev_tx_noack ||
               ev_tx_underrun || ev_rx_abort) begin nm = 0; zero = 1; end
      else if (m_mode == 1) begin zero = 1; if (errbit_end) nm = 0; end
      else if (m_mode == 2) begin zero = 1; if (bus_high) nm = 0; end
      else if (!bus_high) zero = 1;
      if (zero) begin m_sub = 0; m_cnt = 0; end
      else if (tick) begin
        if (m_sub == TPB - 1) begin m_sub = 0; if (m_cnt < CMAX) m_cnt++; end
        else m_sub++;
      end
      m_mode = nm;
      m_el = (nm == 0) && bus_high && (m_cnt >= int'(sft_thresh));
    end
  end

  always @(negedge clk) begin
    tick_ctr++;
    tick <= (tick_ctr % tick_div) == 0;
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk(req, int'(sft_count), m_cnt);
      chk(req, int'(sft_elapsed), int'(m_el));
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_ev();
    ev_tx_done = 0; ev_rx_done = 0; ev_tx_err = 0; ev_tx_noack = 0;
    ev_tx_underrun = 0; ev_rx_abort = 0; rx_abort_errbit = 0;
    errbit_end = 0; ev_bad_start = 0;
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    step(4);
    rst = 0;
    @(posedge clk); #1;
    // R1: reset state
    chk("R1", int'(sft_count), 0);
    chk("R1", int'(sft_elapsed), 0);

    // R2 / R7: climb through threshold to saturation
    req = "R2"; step(55);
    chk("R2", int'(sft_count), CMAX);
    chk("R7", int'(sft_elapsed), 1);

    // R3: each immediate start, mid bit-period, sparse ticks
    req = "R3"; tick_div = 2;
    for (int k = 0; k < 6; k++) begin
      step(1);
      case (k)
        0: ev_tx_done = 1; 1: ev_rx_done = 1; 2: ev_tx_err = 1;
        3: ev_tx_noack = 1; 4: ev_tx_underrun = 1; default: ev_rx_abort = 1;
      endcase
      step(1); clear_ev();
      step(7 + k);
    end

    // R6: line low clears, ticks ignored while low
    req = "R6"; tick_div = 1;
    step(1); bus_high = 0; step(5); bus_high = 1; step(8);

    // R4: abort with error bit holds count until the bit ends
    req = "R4";
    ev_rx_abort = 1; rx_abort_errbit = 1; step(1); clear_ev();
    step(10);
    chk("R4", int'(sft_count), 0);
    errbit_end = 1; step(1); errbit_end = 0; step(9);

    // R5: bad start waits for release of the line
    req = "R5";
    bus_high = 0; ev_bad_start = 1; step(1); clear_ev(); step(4);
    bus_high = 1; step(8);
    ev_bad_start = 1; step(1); clear_ev(); step(6);

    // R9: error-bit end ignored while waiting for idle
    req = "R9";
    bus_high = 0; ev_bad_start = 1; step(1); clear_ev();
    errbit_end = 1; step(1); errbit_end = 0; step(3);
    chk("R9", int'(sft_count), 0);
    bus_high = 1; step(6);

    // R8: collisions
    req = "R8";
    ev_rx_abort = 1; rx_abort_errbit = 1; ev_bad_start = 1; ev_tx_done = 1;
    step(1); clear_ev(); step(6);
    chk("R8", int'(sft_count), 0);
    errbit_end = 1; step(1); errbit_end = 0; step(5);
    bus_high = 0; ev_bad_start = 1; ev_tx_noack = 1; step(1); clear_ev(); step(3);
    bus_high = 1; step(6);

    // R7: threshold 0 and threshold at the maximum, ticks every third cycle
    req = "R7"; tick_div = 3;
    sft_thresh = 0; ev_rx_done = 1; step(1); clear_ev(); step(4);
    chk("R7", int'(sft_elapsed), 1);
    sft_thresh = 4'(CMAX); ev_tx_done = 1; step(1); clear_ev(); step(60);
    step(20);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule